// File: doc/BRIEF.md
# Received-Frame Packet Queue with Word Drain

This block sits between a byte-wide receive path and a processor. Each incoming frame arrives as a stream of bytes, and the final byte carries a last flag. The block writes the frame into a free slot of a circular queue. Every stored packet starts with a two-byte length field and ends with the frame's CRC-32. The packet is then zero-padded to a whole 32-bit word.

The processor empties the queue through a single read strobe. Each strobe returns the next 32-bit word of the oldest packet. When a packet has been fully read, the queue releases its slot and moves on to the next packet without any further command.

A pending-packet count and an interrupt line tell software that there is work to do. A control input drops frames while reception is disabled. A one-cycle pulse discards everything held in the queue.

Top module: `rxq_top`

## Requirements
- R1: The queue has `SLOTS` packet slots. Packets are read back in arrival order, and the read slot index steps through 0 to `SLOTS-1` and then returns to 0.
- R2: A frame whose first byte arrives while `rx_enable` is low, or while `pkt_count` equals `SLOTS`, is dropped as a whole, and `pkt_count` does not change.
- R3: Byte k of a stored packet sits in word k/4 at bits `8*(k%4)+7 : 8*(k%4)`. Bytes 0 and 1 hold the length, which is payload size + 6, low byte first. The payload follows from byte 2 onward.
- R4: The four bytes after the payload are the CRC-32 of the payload, low byte first. The CRC is computed over the reflected polynomial 0xEDB88320, starts from all ones, and is complemented at the end.
- R5: Any byte of the final word beyond the CRC reads as zero.
- R6: Each `rd_req` returns one word on `rd_data`, valid from the cycle after the request.
  - A packet with payload size n takes ceil((n+6)/4) reads.
  - After the last of these reads, `pkt_count` drops by one and the next read starts at byte 0 of the next packet.
- R7: A read while the queue is empty returns zero and raises `rd_underflow` for one cycle. It leaves `pkt_count` and the read position unchanged.
- R8: A `fifo_reset` pulse sets `pkt_count` to 0 and returns the read position to slot 0. It also discards a frame that is partly received, including its later bytes.
- R9: `irq` is high exactly while `pkt_count` is non-zero. A stored packet therefore raises it.
- R10: A frame whose payload exceeds `SLOT_WORDS*4-6` bytes is dropped, and `pkt_count` does not change.
- R11: A frame whose first byte arrives while the previous frame's CRC, padding or length is still being written is dropped as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Accept new frames when high |
| fifo_reset | input | 1 | Pulse: empty the queue |
| rx_valid | input | 1 | A receive byte is present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rd_req | input | 1 | Read strobe for the next queue word |
| rd_data | output | 32 | Word returned by the last read |
| rd_underflow | output | 1 | The last read found the queue empty |
| pkt_count | output | $clog2(SLOTS+1) | Number of stored, unread packets |
| irq | output | 1 | Receive interrupt request |

## Verification
Read results are registered. After a strobe sampled at a rising edge, `rd_data` and `rd_underflow` settle at that edge, and the count decrement after a packet's final word lands at the same edge. The bench therefore drives each strobe at a falling edge and samples at the next falling edge.

A stored packet takes the last payload byte plus up to eight more edges: four CRC bytes, up to three pad bytes and one length write. The bench therefore waits twelve cycles after a frame before checking `pkt_count` and `irq`.

Expected words are rebuilt from the payload seed and length by the byte layout in R3 to R5, with the CRC computed bit by bit. The sweep covers every payload size the small configuration allows, and so every padding amount.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DATA,
    W_FCS,
    W_PAD,
    W_HEAD
  } wr_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam int          PREFIX_BYTES  = 2;
  localparam int          TRAILER_BYTES = 4;

  // One byte of the reflected CRC-32 register update.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  // Stored length counts the prefix, the payload and the CRC.
  function automatic logic [15:0] stored_len(input logic [15:0] payload);
    return payload + 16'(PREFIX_BYTES + TRAILER_BYTES);
  endfunction

endpackage

// File: rtl/rxq_slot_ram.sv
module rxq_slot_ram #(
  parameter int DEPTH = 992,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_frame_writer.sv
module rxq_frame_writer
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_WORDS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_enable,
  input  logic                        fifo_reset,
  input  logic                        rx_valid,
  input  logic [7:0]                  rx_data,
  input  logic                        rx_last,
  input  logic [$clog2(SLOTS+1)-1:0]  count,
  input  logic [$clog2(SLOTS)-1:0]    rd_slot,
  output logic                        wr_en,
  output logic [$clog2(SLOTS)+$clog2(SLOT_WORDS)-1:0] wr_addr,
  output logic [31:0]                 wr_data,
  output logic                        commit
);
  localparam int SLOTW       = $clog2(SLOTS);
  localparam int PTRW        = $clog2(SLOT_WORDS);
  localparam int CNTW        = $clog2(SLOTS+1);
  localparam int SUMW        = SLOTW + 1;
  localparam int SLOT_BYTES  = SLOT_WORDS * 4;
  localparam int POSW        = PTRW + 2;
  localparam int MAX_PAYLOAD = SLOT_BYTES - PREFIX_BYTES - TRAILER_BYTES;

  wr_state_e        state_q;
  logic             skip_q;
  logic [POSW-1:0]  pos_q;
  logic [15:0]      cnt_q;
  logic [31:0]      crc_q;
  logic [31:0]      asm_q;
  logic [15:0]      head_q;
  logic [1:0]       fcs_idx_q;
  logic [SLOTW-1:0] slot_q;

  // Named internal events
  logic             start_ok;
  logic             too_long;
  logic             push_en;
  logic [7:0]       push_byte;
  logic [1:0]       lane;
  logic [31:0]      merged;
  logic [31:0]      fcs_w;
  logic [SUMW-1:0]  slot_sum;
  logic [SLOTW-1:0] next_slot;

  assign start_ok  = rx_enable && (count < CNTW'(SLOTS));
  assign too_long  = (cnt_q == 16'(MAX_PAYLOAD));
  assign lane      = pos_q[1:0];
  assign fcs_w     = ~crc_q;
  assign slot_sum  = SUMW'(rd_slot) + SUMW'(count);
  assign next_slot = (slot_sum >= SUMW'(SLOTS)) ? SLOTW'(slot_sum - SUMW'(SLOTS))
                                                : SLOTW'(slot_sum);

  always_comb begin
    push_en   = 1'b0;
    push_byte = 8'd0;
    case (state_q)
      W_IDLE: begin
        push_en   = rx_valid && !skip_q && start_ok;
        push_byte = rx_data;
      end
      W_DATA: begin
        push_en   = rx_valid && !too_long;
        push_byte = rx_data;
      end
      W_FCS: begin
        push_en   = 1'b1;
        push_byte = fcs_w[8*fcs_idx_q +: 8];
      end
      W_PAD: begin
        push_en   = 1'b1;
        push_byte = 8'd0;
      end
      default: ;
    endcase
    if (fifo_reset) push_en = 1'b0;
  end

  always_comb begin
    merged = asm_q;
    merged[8*lane +: 8] = push_byte;
  end

  assign commit  = (state_q == W_HEAD) && !fifo_reset;
  assign wr_en   = (push_en && (lane == 2'd3)) || commit;
  assign wr_addr = commit ? {slot_q, {PTRW{1'b0}}} : {slot_q, pos_q[POSW-1:2]};
  assign wr_data = commit ? {head_q, stored_len(cnt_q)} : merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= W_IDLE;
      skip_q    <= 1'b0;
      pos_q     <= POSW'(PREFIX_BYTES);
      cnt_q     <= 16'd0;
      crc_q     <= '1;
      asm_q     <= 32'd0;
      head_q    <= 16'd0;
      fcs_idx_q <= 2'd0;
      slot_q    <= '0;
    end else begin
      if (push_en) begin
        asm_q <= merged;
        pos_q <= pos_q + POSW'(1);
        if (pos_q == POSW'(2)) head_q[7:0]  <= push_byte;
        if (pos_q == POSW'(3)) head_q[15:8] <= push_byte;
      end
      if (fifo_reset) begin
        state_q <= W_IDLE;
        pos_q   <= POSW'(PREFIX_BYTES);
        skip_q  <= ((state_q == W_DATA) || skip_q) && !(rx_valid && rx_last);
      end else begin
        case (state_q)
          W_IDLE: if (rx_valid) begin
            if (skip_q) begin
              skip_q <= !rx_last;
            end else if (start_ok) begin
              slot_q    <= next_slot;
              cnt_q     <= 16'd1;
              crc_q     <= crc_step('1, rx_data);
              fcs_idx_q <= 2'd0;
              state_q   <= rx_last ? W_FCS : W_DATA;
            end else begin
              skip_q <= !rx_last;
            end
          end
          W_DATA: if (rx_valid) begin
            if (too_long) begin
              state_q <= W_IDLE;
              pos_q   <= POSW'(PREFIX_BYTES);
              skip_q  <= !rx_last;
            end else begin
              cnt_q <= cnt_q + 16'd1;
              crc_q <= crc_step(crc_q, rx_data);
              if (rx_last) state_q <= W_FCS;
            end
          end
          W_FCS: begin
            fcs_idx_q <= fcs_idx_q + 2'd1;
            if (fcs_idx_q == 2'd3) state_q <= (lane == 2'd3) ? W_HEAD : W_PAD;
            if (rx_valid) skip_q <= !rx_last;
          end
          W_PAD: begin
            if (lane == 2'd3) state_q <= W_HEAD;
            if (rx_valid) skip_q <= !rx_last;
          end
          W_HEAD: begin
            state_q <= W_IDLE;
            pos_q   <= POSW'(PREFIX_BYTES);
            if (rx_valid) skip_q <= !rx_last;
          end
          default: state_q <= W_IDLE;
        endcase
      end
    end
  end

  // R5: the length word is written only once the packet ends on a word boundary
  assert_head_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_HEAD) |-> (pos_q[1:0] == 2'b00));

  // R2: a packet is committed only into a free slot
  assert_commit_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (count < CNTW'(SLOTS)));

  // R10: payload count never passes the slot capacity
  assert_payload_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_DATA) |-> (cnt_q <= 16'(MAX_PAYLOAD)));

  // R4: exactly four CRC bytes, then padding or the length word
  assert_fcs_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_FCS && fcs_idx_q == 2'd3 && !fifo_reset) |=> (state_q == W_PAD || state_q == W_HEAD));
endmodule

// File: rtl/rxq_reader.sv
module rxq_reader #(
  parameter int SLOTS      = 31,
  parameter int SLOT_WORDS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fifo_reset,
  input  logic                        rd_req,
  input  logic                        commit,
  input  logic [31:0]                 rdata,
  output logic [$clog2(SLOTS)+$clog2(SLOT_WORDS)-1:0] raddr,
  output logic [31:0]                 rd_data,
  output logic                        rd_underflow,
  output logic [$clog2(SLOTS+1)-1:0]  count,
  output logic [$clog2(SLOTS)-1:0]    rd_slot
);
  localparam int SLOTW = $clog2(SLOTS);
  localparam int PTRW  = $clog2(SLOT_WORDS);
  localparam int CNTW  = $clog2(SLOTS+1);

  logic               active_q;
  logic [PTRW-1:0]    ptr_q;
  logic signed [17:0] rem_q;
  logic [CNTW-1:0]    count_q;
  logic [SLOTW-1:0]   slot_q;

  // Named internal events
  logic               empty;
  logic               fetch;
  logic               done;
  logic signed [17:0] rem_next;

  assign raddr    = {slot_q, active_q ? ptr_q : {PTRW{1'b0}}};
  assign rem_next = active_q ? (rem_q - 18'sd4) : ($signed({2'b00, rdata[15:0]}) - 18'sd4);
  assign empty    = !active_q && (count_q == '0);
  assign fetch    = rd_req && !fifo_reset && !empty;
  assign done     = fetch && (rem_next <= 18'sd0);
  assign count    = count_q;
  assign rd_slot  = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      ptr_q        <= '0;
      rem_q        <= '0;
      count_q      <= '0;
      slot_q       <= '0;
      rd_data      <= 32'd0;
      rd_underflow <= 1'b0;
    end else if (fifo_reset) begin
      active_q     <= 1'b0;
      ptr_q        <= '0;
      count_q      <= '0;
      slot_q       <= '0;
      rd_underflow <= 1'b0;
    end else begin
      rd_underflow <= rd_req && empty;
      if (rd_req) rd_data <= empty ? 32'd0 : rdata;
      if (fetch) begin
        if (done) begin
          active_q <= 1'b0;
          ptr_q    <= '0;
          slot_q   <= (slot_q == SLOTW'(SLOTS-1)) ? '0 : slot_q + SLOTW'(1);
        end else begin
          active_q <= 1'b1;
          ptr_q    <= (active_q ? ptr_q : '0) + PTRW'(1);
          rem_q    <= rem_next;
        end
      end
      count_q <= count_q + CNTW'(commit) - CNTW'(done);
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNTW'(SLOTS));

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SLOTW'(SLOTS));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !fifo_reset && !commit) |=> (rd_underflow && count_q == '0 && $stable(slot_q)));

  assert_reset_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (count_q == '0 && slot_q == '0 && !active_q));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !commit) |=> (count_q == $past(count_q) - CNTW'(1)));
endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
  parameter int SLOTS      = 31,
  parameter int SLOT_WORDS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_enable,
  input  logic                       fifo_reset,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic                       rx_last,
  input  logic                       rd_req,
  output logic [31:0]                rd_data,
  output logic                       rd_underflow,
  output logic [$clog2(SLOTS+1)-1:0] pkt_count,
  output logic                       irq
);
  localparam int SLOTW = $clog2(SLOTS);
  localparam int PTRW  = $clog2(SLOT_WORDS);
  localparam int AW    = SLOTW + PTRW;
  localparam int DEPTH = SLOTS * SLOT_WORDS;

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [31:0]      wr_data;
  logic [AW-1:0]    raddr;
  logic [31:0]      rdata;
  logic             commit;
  logic [SLOTW-1:0] rd_slot;

  rxq_frame_writer #(.SLOTS(SLOTS), .SLOT_WORDS(SLOT_WORDS)) u_writer (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .fifo_reset(fifo_reset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .count(pkt_count), .rd_slot(rd_slot),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit)
  );

  rxq_slot_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  rxq_reader #(.SLOTS(SLOTS), .SLOT_WORDS(SLOT_WORDS)) u_reader (
    .clk(clk), .rst_n(rst_n), .fifo_reset(fifo_reset), .rd_req(rd_req),
    .commit(commit), .rdata(rdata), .raddr(raddr),
    .rd_data(rd_data), .rd_underflow(rd_underflow),
    .count(pkt_count), .rd_slot(rd_slot)
  );

  assign irq = (pkt_count != '0);

  // R9: a committed packet leaves the interrupt raised
  assert_irq_on_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq);
endmodule

// File: tb/tb_rxq_top.sv
`timescale 1ns/1ps
module tb_rxq_top;
  localparam int SLOTS      = 5;
  localparam int SLOT_WORDS = 8;
  localparam int MAXP       = SLOT_WORDS*4 - 6;
  localparam int CNTW       = $clog2(SLOTS+1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rx_enable = 1'b1;
  logic            fifo_reset = 1'b0;
  logic            rx_valid = 1'b0;
  logic [7:0]      rx_data = 8'd0;
  logic            rx_last = 1'b0;
  logic            rd_req = 1'b0;
  logic [31:0]     rd_data;
  logic            rd_underflow;
  logic [CNTW-1:0] pkt_count;
  logic            irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rxq_top #(.SLOTS(SLOTS), .SLOT_WORDS(SLOT_WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .fifo_reset(fifo_reset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rd_req(rd_req),
    .rd_data(rd_data), .rd_underflow(rd_underflow), .pkt_count(pkt_count), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'(seed*29 + i*13 + 5);
  endfunction

  function automatic logic [31:0] frame_crc(input int seed, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, pbyte(seed, i)};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  // R3 R4 R5: byte k of the stored image
  function automatic logic [7:0] img_byte(input int seed, input int n, input int k);
    logic [15:0] len = 16'(n + 6);
    logic [31:0] c   = frame_crc(seed, n);
    if (k == 0) return len[7:0];
    if (k == 1) return len[15:8];
    if (k < n + 2) return pbyte(seed, k - 2);
    if (k < n + 6) return c[8*(k-n-2) +: 8];
    return 8'd0;
  endfunction

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic last);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_last = last;
  endtask

  task automatic stop_rx();
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic drive_frame(input int seed, input int n);
    for (int i = 0; i < n; i++) put_byte(pbyte(seed, i), i == n-1);
  endtask

  task automatic send_frame(input int seed, input int n);
    drive_frame(seed, n);
    stop_rx();
    idle(12);
  endtask

  task automatic read_word(output logic [31:0] w, output logic uf);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    w  = rd_data;
    uf = rd_underflow;
  endtask

  task automatic read_check(input int seed, input int n, input string req);
    int words = (n + 6 + 3) / 4;
    logic [31:0] w, e;
    logic uf;
    for (int i = 0; i < words; i++) begin
      read_word(w, uf);
      e = {img_byte(seed, n, 4*i+3), img_byte(seed, n, 4*i+2),
           img_byte(seed, n, 4*i+1), img_byte(seed, n, 4*i)};
      check(w == e, req, w, e);
      check(!uf, {req, " R6 no underflow"}, 32'(uf), 32'd0);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); fifo_reset = 1'b1;
    @(negedge clk); fifo_reset = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    logic uf;
    int sizes[5] = '{3, 10, MAXP, 1, 17};
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(pkt_count == 0, "R9 reset count", 32'(pkt_count), 0);
    check(irq == 0, "R9 reset irq", 32'(irq), 0);
    check(rd_underflow == 0, "R7 reset underflow", 32'(rd_underflow), 0);

    // R7: empty read
    read_word(w, uf);
    check(w == 0, "R7 empty data", w, 0);
    check(uf == 1, "R7 underflow flag", 32'(uf), 1);
    check(pkt_count == 0, "R7 count unchanged", 32'(pkt_count), 0);

    // Sweep every payload size: R3 R4 R5 R6 R9, slot wrap R1
    for (int n = 1; n <= MAXP; n++) begin
      send_frame(n, n);
      check(pkt_count == 1, "R9 count after store", 32'(pkt_count), 1);
      check(irq == 1, "R9 irq after store", 32'(irq), 1);
      read_check(n, n, "R3/R4/R5 sweep word");
      check(pkt_count == 0, "R6 count after drain", 32'(pkt_count), 0);
      check(irq == 0, "R9 irq after drain", 32'(irq), 0);
    end

    // R10: oversize frames dropped, following frame intact
    send_frame(40, MAXP + 1);
    check(pkt_count == 0, "R10 oversize dropped", 32'(pkt_count), 0);
    send_frame(41, MAXP + 5);
    check(pkt_count == 0, "R10 oversize dropped", 32'(pkt_count), 0);
    send_frame(42, 9);
    check(pkt_count == 1, "R10 next frame kept", 32'(pkt_count), 1);
    read_check(42, 9, "R10 next frame word");

    // R2: disabled
    rx_enable = 1'b0;
    send_frame(50, 6);
    check(pkt_count == 0, "R2 disabled drop", 32'(pkt_count), 0);
    rx_enable = 1'b1;

    // R1 R2: fill the ring, overflow drop, read in order
    for (int i = 0; i < SLOTS; i++) send_frame(60 + i, sizes[i]);
    check(pkt_count == CNTW'(SLOTS), "R1 ring full", 32'(pkt_count), SLOTS);
    send_frame(70, 8);
    check(pkt_count == CNTW'(SLOTS), "R2 full drop", 32'(pkt_count), SLOTS);
    for (int i = 0; i < SLOTS; i++) begin
      read_check(60 + i, sizes[i], "R1 order word");
      check(pkt_count == CNTW'(SLOTS-1-i), "R6 count step", 32'(pkt_count), 32'(SLOTS-1-i));
    end
    read_word(w, uf);
    check(uf == 1, "R7 underflow after drain", 32'(uf), 1);

    // R8: reset in the middle of reading
    send_frame(80, 12);
    send_frame(81, 7);
    read_word(w, uf);
    pulse_reset();
    check(pkt_count == 0, "R8 count cleared", 32'(pkt_count), 0);
    check(irq == 0, "R8 irq cleared", 32'(irq), 0);
    read_word(w, uf);
    check(uf == 1, "R8 empty after reset", 32'(uf), 1);
    send_frame(82, 11);
    read_check(82, 11, "R8 frame after reset");

    // R8: partial frame discarded across a reset
    put_byte(8'h11, 1'b0);
    put_byte(8'h22, 1'b0);
    stop_rx();
    pulse_reset();
    put_byte(8'h33, 1'b0);
    put_byte(8'h44, 1'b1);
    stop_rx();
    idle(12);
    check(pkt_count == 0, "R8 partial frame discarded", 32'(pkt_count), 0);
    send_frame(83, 5);
    check(pkt_count == 1, "R8 later frame kept", 32'(pkt_count), 1);
    read_check(83, 5, "R8 later frame word");

    // R11: frame starting during the previous frame's trailer
    drive_frame(90, 8);
    drive_frame(91, 5);
    stop_rx();
    idle(12);
    check(pkt_count == 1, "R11 back-to-back drop", 32'(pkt_count), 1);
    read_check(90, 8, "R11 first frame word");
    read_word(w, uf);
    check(uf == 1, "R11 nothing else stored", 32'(uf), 1);

    finish_run();
  end
endmodule